// File: doc/BRIEF.md
# Bus cycle strobe generator

This block produces three auxiliary control strobes from the timing of a bus transfer. The sequencer supplies four inputs: a one-clock start pulse, the transfer direction, the live read/write level, and a per-datum acknowledge. From these the block derives three outputs. The first is an active-low memory strobe that pulses once per datum. The second is an I/O strobe that fires only in the second clock of a transfer. The third is an extended data enable that covers the whole read/write window and lasts half a clock past its end.

An 8-bit configuration word selects which transfer directions each strobe follows, so each strobe fires on reads, on writes, on both, or never. The same word can turn the I/O strobe pin and the extended enable pin into general-purpose condition inputs. In that mode the pin's output enable is released. The external level passes through a multi-flop synchronizer and is presented as a condition bit for branch logic.

The configuration bits are: bit 0 memory strobe on reads, bit 1 memory strobe on writes, bit 2 I/O strobe on reads, bit 3 I/O strobe on writes, bit 4 extended enable on reads, bit 5 extended enable on writes, bit 6 I/O pin as input, and bit 7 extended enable pin as input. The transfer direction is taken from `xfer_write` in the start cycle and held for the rest of the transfer.

Top module: `bus_strobe_gen`

## Requirements
- R1: While reset is held and on the first clock after it, `mem_strobe_n` is 1. In the same period `io_strobe_o`, `xde_o`, `io_strobe_oe`, `xde_oe`, `cond_io` and `cond_xde` are 0 (the condition outputs are 0 when the pins are in output mode).
- R2: With the memory strobe enabled for the transfer's direction, `mem_strobe_n` goes low in the second clock of the transfer (the clock after `xfer_start`). It stays low up to and including the clock in which `beat_ack` is sampled.
- R3: After each acknowledged datum, `mem_strobe_n` is high for exactly one clock. It goes low again on the next clock if `xfer_rw` is still high in that gap clock, and stays high if `xfer_rw` has dropped.
- R4: With the I/O pin in output mode and the I/O strobe enabled for the direction, `io_strobe_o` is high for exactly one clock, the second clock of the transfer.
- R5: With the enable pin in output mode and enabled for the direction, `xde_o` rises at the start of the second clock of the transfer. It stays high through the clock after the last clock in which `xfer_rw` is high, and falls at the falling clock edge half a clock later.
- R6: Each strobe follows only the directions its two configuration bits select. A strobe with both bits 0 stays inactive for reads and for writes.
- R7: When bit 6 (or bit 7) is 1, the matching output enable is 0 from the next clock, and the matching strobe output stays 0 through every transfer.
- R8: In input mode a level on `io_pin_in` (or `xde_pin_in`) reaches `cond_io` (or `cond_xde`) after exactly two rising clock edges. In output mode the condition output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 8 | Strobe mode and pin-direction configuration |
| xfer_start | input | 1 | One-clock pulse in the first clock of a transfer |
| xfer_write | input | 1 | Transfer direction, 1 = write, sampled with xfer_start |
| xfer_rw | input | 1 | Read/write level from the sequencer, high while the transfer runs |
| beat_ack | input | 1 | Acknowledge of the current datum |
| io_pin_in | input | 1 | External level of the I/O strobe pin |
| xde_pin_in | input | 1 | External level of the extended enable pin |
| mem_strobe_n | output | 1 | Active-low memory strobe |
| io_strobe_o | output | 1 | I/O strobe output value |
| io_strobe_oe | output | 1 | Output enable for the I/O strobe pin |
| xde_o | output | 1 | Extended data enable output value |
| xde_oe | output | 1 | Output enable for the extended enable pin |
| cond_io | output | 1 | Synchronized condition from the I/O pin |
| cond_xde | output | 1 | Synchronized condition from the extended enable pin |

## Verification
The bench runs transfers through every combination of the three direction modes (64), both pin-direction settings of each dual pin, and both directions. It uses three beat shapes: a single short datum, two longer data, and four back-to-back short data. Together these show a wrong mode decode, an off-by-one in the second-clock placement, a missing or doubled inter-beat gap, and a strobe that re-arms after the final acknowledge. The extended enable is sampled at both the quarter and three-quarter points of each clock, which catches a missing or full-clock extension. The synchronizer is probed one and two edges after a pin change to pin its latency, and again in output mode to confirm the condition stays 0.

// File: rtl/strobe_gen_pkg.sv
package strobe_gen_pkg;

  localparam int CFG_W      = 8;
  localparam int MEM_SEL_LO = 0;
  localparam int IO_SEL_LO  = 2;
  localparam int XDE_SEL_LO = 4;
  localparam int IO_IN_BIT  = 6;
  localparam int XDE_IN_BIT = 7;

  // Direction selector: which transfer kinds a strobe follows.
  typedef struct packed {
    logic on_wr;
    logic on_rd;
  } dir_sel_t;

  function automatic logic sel_hit(input dir_sel_t sel, input logic is_wr);
    return is_wr ? sel.on_wr : sel.on_rd;
  endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sg_mem_strobe.sv
module sg_mem_strobe
  import strobe_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dir_sel_t sel,
  input  logic     cur_wr,
  input  logic     xfer_rw,
  input  logic     beat_ack,
  output logic     strobe_n
);
  logic active;

  // Low while a datum is outstanding; the acknowledge forces one idle clock
  // before the next datum, and a dropped read/write level ends the train.
  always_ff @(posedge clk) begin
    if (rst) active <= 1'b0;
    else     active <= xfer_rw & ~beat_ack & sel_hit(sel, cur_wr);
  end

  assign strobe_n = ~active;
endmodule

// File: rtl/sg_io_pulse.sv
module sg_io_pulse
  import strobe_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dir_sel_t sel,
  input  logic     as_input,
  input  logic     xfer_start,
  input  logic     xfer_write,
  output logic     pulse,
  output logic     oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      oe    <= 1'b0;
    end else begin
      pulse <= xfer_start & sel_hit(sel, xfer_write) & ~as_input;
      oe    <= ~as_input;
    end
  end
endmodule

// File: rtl/sg_ext_enable.sv
module sg_ext_enable
  import strobe_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dir_sel_t sel,
  input  logic     as_input,
  input  logic     cur_wr,
  input  logic     xfer_rw,
  output logic     enable,
  output logic     oe
);
  logic rise_q;
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      oe     <= 1'b0;
    end else begin
      rise_q <= xfer_rw & sel_hit(sel, cur_wr) & ~as_input;
      oe     <= ~as_input;
    end
  end

  // Falling-edge copy keeps the enable up for half a clock after rise_q drops.
  always_ff @(negedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= rise_q;
  end

  assign enable = rise_q | hold_q;
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import strobe_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             xfer_start,
  input  logic             xfer_write,
  input  logic             xfer_rw,
  input  logic             beat_ack,
  input  logic             io_pin_in,
  input  logic             xde_pin_in,
  output logic             mem_strobe_n,
  output logic             io_strobe_o,
  output logic             io_strobe_oe,
  output logic             xde_o,
  output logic             xde_oe,
  output logic             cond_io,
  output logic             cond_xde
);
  localparam int NUM_DUAL = 2;

  dir_sel_t mem_sel, io_sel, xde_sel;
  logic     dir_q, cur_wr;
  logic [NUM_DUAL-1:0] pin_in, pin_mode_in, pin_sync;

  assign mem_sel = dir_sel_t'(cfg[MEM_SEL_LO +: 2]);
  assign io_sel  = dir_sel_t'(cfg[IO_SEL_LO  +: 2]);
  assign xde_sel = dir_sel_t'(cfg[XDE_SEL_LO +: 2]);

  always_ff @(posedge clk) begin
    if (rst)             dir_q <= 1'b0;
    else if (xfer_start) dir_q <= xfer_write;
  end
  assign cur_wr = xfer_start ? xfer_write : dir_q;

  sg_mem_strobe u_mem (
    .clk(clk), .rst(rst), .sel(mem_sel), .cur_wr(cur_wr),
    .xfer_rw(xfer_rw), .beat_ack(beat_ack), .strobe_n(mem_strobe_n)
  );

  sg_io_pulse u_io (
    .clk(clk), .rst(rst), .sel(io_sel), .as_input(cfg[IO_IN_BIT]),
    .xfer_start(xfer_start), .xfer_write(xfer_write),
    .pulse(io_strobe_o), .oe(io_strobe_oe)
  );

  sg_ext_enable u_xde (
    .clk(clk), .rst(rst), .sel(xde_sel), .as_input(cfg[XDE_IN_BIT]),
    .cur_wr(cur_wr), .xfer_rw(xfer_rw), .enable(xde_o), .oe(xde_oe)
  );

  assign pin_in      = {xde_pin_in, io_pin_in};
  assign pin_mode_in = {cfg[XDE_IN_BIT], cfg[IO_IN_BIT]};

  generate
    for (genvar p = 0; p < NUM_DUAL; p++) begin : g_pin
      sg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in[p]), .q(pin_sync[p])
      );
    end
  endgenerate

  assign cond_io  = pin_mode_in[0] & pin_sync[0];
  assign cond_xde = pin_mode_in[1] & pin_sync[1];
endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cfg,
  input logic       xfer_start,
  input logic       xfer_rw,
  input logic       beat_ack,
  input logic       mem_strobe_n,
  input logic       io_strobe_o,
  input logic       io_strobe_oe
);
  // R2: the memory strobe only falls inside a running transfer
  assert_mem_in_xfer_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_strobe_n) |-> ($past(xfer_start) || $past(xfer_rw)));

  // R3: an acknowledged datum is followed by a high clock
  assert_mem_gap_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(beat_ack) && !$past(mem_strobe_n)) |-> mem_strobe_n);

  // R4: the I/O strobe only follows a start pulse
  assert_io_second_clock_R4: assert property (@(posedge clk) disable iff (rst)
    io_strobe_o |-> $past(xfer_start));

  // R6: a memory strobe selected for neither direction stays high
  assert_mem_never_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg[1:0]) == 2'b00) |-> mem_strobe_n);

  // R7: a released pin carries no strobe
  assert_io_released_R7: assert property (@(posedge clk) disable iff (rst)
    !io_strobe_oe |-> !io_strobe_o);
endmodule

bind bus_strobe_gen bus_strobe_gen_chk u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .xfer_start(xfer_start),
  .xfer_rw(xfer_rw), .beat_ack(beat_ack), .mem_strobe_n(mem_strobe_n),
  .io_strobe_o(io_strobe_o), .io_strobe_oe(io_strobe_oe)
);

// File: tb/sim_bus_strobe_gen.sv
`timescale 1ns/100ps
module sim_bus_strobe_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg = 8'h00;
  logic       xfer_start = 1'b0, xfer_write = 1'b0, xfer_rw = 1'b0, beat_ack = 1'b0;
  logic       io_pin_in = 1'b0, xde_pin_in = 1'b0;
  logic       mem_strobe_n, io_strobe_o, io_strobe_oe, xde_o, xde_oe, cond_io, cond_xde;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_strobe_gen u0 (
    .clk(clk), .rst(rst), .cfg(cfg), .xfer_start(xfer_start),
    .xfer_write(xfer_write), .xfer_rw(xfer_rw), .beat_ack(beat_ack),
    .io_pin_in(io_pin_in), .xde_pin_in(xde_pin_in),
    .mem_strobe_n(mem_strobe_n), .io_strobe_o(io_strobe_o),
    .io_strobe_oe(io_strobe_oe), .xde_o(xde_o), .xde_oe(xde_oe),
    .cond_io(cond_io), .cond_xde(cond_xde)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cfg=%h: actual=%b expected=%b at %0t", req, what, cfg, act, exp, $time);
    end
  endtask

  function automatic logic hit(input logic [1:0] sel, input logic wr);
    return wr ? sel[1] : sel[0];
  endfunction

  // Runs one transfer of nb data, each held bl clocks, and checks every clock.
  task automatic run_xfer(input logic wr, input int nb, input int bl);
    int last_ack = nb * (bl + 1);
    logic en_mem = hit(cfg[1:0], wr);
    logic en_io  = hit(cfg[3:2], wr) & ~cfg[6];
    logic en_xde = hit(cfg[5:4], wr) & ~cfg[7];
    for (int c = 1; c <= last_ack + 3; c++) begin
      logic exp_mem_low, exp_xq, exp_x3;
      @(posedge clk);
      #0.5;
      xfer_start = (c == 1);
      xfer_write = wr;
      xfer_rw    = (c <= last_ack);
      beat_ack   = (c >= 2) && (c <= last_ack) && (((c - 1) % (bl + 1)) == bl);
      #0.5;
      exp_mem_low = en_mem && (c >= 2) && (c <= last_ack) && (((c - 1) % (bl + 1)) != 0);
      exp_xq = en_xde && (c >= 2) && (c <= last_ack + 2);
      exp_x3 = en_xde && (c >= 2) && (c <= last_ack + 1);
      chk(mem_strobe_n, ~exp_mem_low, "R2/R3/R6", "mem_strobe_n");
      chk(io_strobe_o, en_io && (c == 2), "R4/R6/R7", "io_strobe_o");
      chk(xde_o, exp_xq, "R5/R6/R7", "xde_o early");
      chk(io_strobe_oe, ~cfg[6], "R7", "io_strobe_oe");
      chk(xde_oe, ~cfg[7], "R7", "xde_oe");
      #2;
      chk(xde_o, exp_x3, "R5", "xde_o late");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(mem_strobe_n, 1'b1, "R1", "reset mem");
    chk(io_strobe_o, 1'b0, "R1", "reset io");
    chk(xde_o, 1'b0, "R1", "reset xde");
    chk(io_strobe_oe, 1'b0, "R1", "reset io oe");
    chk(xde_oe, 1'b0, "R1", "reset xde oe");
    chk(cond_io, 1'b0, "R1", "reset cond io");
    chk(cond_xde, 1'b0, "R1", "reset cond xde");
    @(posedge clk);
    #0.5 rst = 1'b0;
    @(posedge clk);
    #1;
    chk(mem_strobe_n, 1'b1, "R1", "post-reset mem");
    chk(io_strobe_o, 1'b0, "R1", "post-reset io");

    // Sweep: pin directions x direction modes x direction x beat shapes (R2..R7)
    for (int im = 0; im < 4; im++) begin
      for (int m = 0; m < 64; m++) begin
        @(posedge clk);
        #0.5 cfg = {im[1:0], m[5:0]};
        repeat (2) @(posedge clk);
        for (int w = 0; w < 2; w++) begin
          run_xfer(w[0], 1, 1);
          run_xfer(w[0], 2, 2);
          run_xfer(w[0], 4, 1);
        end
      end
    end

    // R8: synchronizer latency and output-mode masking
    for (int im = 0; im < 4; im++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        logic exp_io_old, exp_xde_old;
        @(posedge clk);
        #0.5;
        cfg = {im[1:0], 6'h00};
        io_pin_in = ~lvl[0];
        xde_pin_in = ~lvl[0];
        repeat (3) @(posedge clk);
        exp_io_old  = im[0] & ~lvl[0];
        exp_xde_old = im[1] & ~lvl[0];
        #0.5;
        io_pin_in = lvl[0];
        xde_pin_in = lvl[0];
        @(posedge clk);
        #1;
        chk(cond_io, exp_io_old, "R8", "cond_io after one edge");
        chk(cond_xde, exp_xde_old, "R8", "cond_xde after one edge");
        @(posedge clk);
        #1;
        chk(cond_io, im[0] & lvl[0], "R8", "cond_io after two edges");
        chk(cond_xde, im[1] & lvl[0], "R8", "cond_xde after two edges");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule